// File: doc/BRIEF.md
# Audio Clock Ratio Detector and Rate Generator

This block runs in the converter's master-clock domain. The master clock is its `clk_i`. In slave mode it measures how many master-clock cycles fall between rising edges of the incoming frame clock. It then decides whether the master clock is 256, 384, 512 or 768 times the sample rate. Once the same ratio has been seen in two back-to-back frames, it emits a clock-enable strobe that fires exactly 256 times per frame. That strobe is the one internal 256fs timebase, whatever the input ratio.

In master mode the block divides the master clock down by 256 or by 512, as chosen by a select pin. From that count it drives a 1fs frame clock and a 64fs bit clock. It then feeds its own frame clock back through the same detector, so both modes share one lock and one enable path.

The converter is held in power-down until a valid ratio is locked, and whenever the power pin is low. It is also held there when the frame clock stops for too long, and a clock-loss flag is raised.

Top module: `fs_ratio_clk_ctrl`

## Requirements
- R1: In slave mode a frame period of N master cycles is classed by code: 256±2 → 0, 384±2 → 1, 512±2 → 2, 768±2 → 3, shown on `ratio_o` while `ratio_ok_o` is high. While locked, `ratio_o` does not change.
- R2: `ratio_ok_o` rises only after two consecutive measured periods fall in the same class. The first frame-clock edge after reset or after clock loss only starts a measurement. Alternating classes never lock.
- R3: A measured period outside every ±2 window sets `bad_ratio_o` and clears `ratio_ok_o`. The next in-window measurement clears `bad_ratio_o`.
- R4: While locked with a steady period equal to the detected ratio, `en256_o` pulses exactly 256 times per frame period. `en256_o` is low in any cycle whose preceding cycle was unlocked.
- R5: In master mode `lrck_o` is high for the upper half of each 256- or 512-cycle frame. `bclk_o` has a period of 1/64 frame with 50% duty, and it is low whenever `lrck_o` rises.
- R6: In master mode `ratio_sel_i` = 0 selects 256 (code 0) and 1 selects 512 (code 2). `lrck_i` is ignored, and the block locks to its own frame clock.
- R7: With no frame-clock rising edge for 1024 master cycles, `clk_lost_o` goes high and lock is cleared.
- R8: `pd_o` is high when `pwr_en_i` is low or `ratio_ok_o` is low, including during and straight after reset.
- R9: In slave mode `lrck_o` and `bclk_o` are held low.
- R10: After clock loss, a resumed valid frame clock relocks through the R2 sequence and clears `clk_lost_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lrck_i | input | 1 | Frame clock input (slave mode) |
| master_i | input | 1 | 1 = master mode, 0 = slave mode |
| ratio_sel_i | input | 1 | Master ratio: 0 = 256fs, 1 = 512fs |
| pwr_en_i | input | 1 | Power pin, low forces power-down |
| lrck_o | output | 1 | Generated frame clock (master mode) |
| bclk_o | output | 1 | Generated 64fs bit clock (master mode) |
| en256_o | output | 1 | 256fs clock-enable strobe |
| ratio_o | output | 2 | Locked ratio code |
| ratio_ok_o | output | 1 | Ratio locked |
| bad_ratio_o | output | 1 | Last measured period was out of range |
| clk_lost_o | output | 1 | Frame clock absent for 1024 cycles |
| pd_o | output | 1 | Converter held in power-down |

## Verification
The hardest state to reach from the pins is a lock on a period that sits on the edge of a tolerance window, followed by a period just outside it. Another is the sequence of clock loss and relock with a fresh first-edge measurement. The stimulus drives frame periods of 386, 258 and then 259 cycles. It alternates 256 and 512 periods to deny lock, and it stops the frame clock for 1100 cycles before resuming it. A behavioural model, fed the same pin activity, predicts every flag for every cycle.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int unsigned NUM_RATIOS = 4;

  typedef enum logic [1:0] {
    RATIO_256 = 2'd0,
    RATIO_384 = 2'd1,
    RATIO_512 = 2'd2,
    RATIO_768 = 2'd3
  } ratio_e;

  function automatic int unsigned ratio_len(input int unsigned base, input logic [1:0] code);
    case (code)
      2'd0:    return base;
      2'd1:    return (base * 3) / 2;
      2'd2:    return base * 2;
      default: return base * 3;
    endcase
  endfunction
endpackage

// File: rtl/acr_lrck_meter.sv
module acr_lrck_meter #(
  parameter int unsigned LOSS_CYC = 1024,
  localparam int unsigned CNT_W = $clog2(LOSS_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lrck_i,
  output logic             rise_o,
  output logic             meas_vld_o,
  output logic [CNT_W-1:0] meas_o,
  output logic             lost_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOSS_CYC);

  logic [2:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;

  assign rise_o     = sync_q[1] & ~sync_q[2];
  assign lost_o     = (cnt_q == LIMIT);
  assign meas_vld_o = rise_o & seen_q;
  assign meas_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], lrck_i};
      if (rise_o)              cnt_q <= CNT_W'(1);
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      if (rise_o)      seen_q <= 1'b1;
      else if (lost_o) seen_q <= 1'b0;
    end
  end

  // R7: the loss count saturates until an edge returns
  p_loss_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o && !rise_o |=> lost_o);
endmodule

// File: rtl/acr_ratio_judge.sv
module acr_ratio_judge
  import acr_pkg::*;
#(
  parameter int unsigned BASE  = 256,
  parameter int unsigned TOL   = 2,
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             meas_vld_i,
  input  logic [CNT_W-1:0] meas_i,
  input  logic             lost_i,
  output logic             locked_o,
  output logic [1:0]       ratio_o,
  output logic             bad_o
);
  logic [NUM_RATIOS-1:0] hit;
  logic [1:0]            cls;
  logic                  cls_ok, lock_n;
  logic [1:0]            prev_cls_q;
  logic                  prev_ok_q;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
    localparam int unsigned L = ratio_len(BASE, 2'(g));
    localparam logic [CNT_W-1:0] LO = CNT_W'(L - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(L + TOL);
    assign hit[g] = (meas_i >= LO) && (meas_i <= HI);
  end

  always_comb begin
    cls = '0;
    for (int i = 0; i < NUM_RATIOS; i++) if (hit[i]) cls = 2'(i);
  end

  assign cls_ok = |hit;
  assign lock_n = cls_ok && prev_ok_q && (cls == prev_cls_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_cls_q <= '0;
      prev_ok_q  <= 1'b0;
      locked_o   <= 1'b0;
      ratio_o    <= '0;
      bad_o      <= 1'b0;
    end else if (meas_vld_i) begin
      prev_cls_q <= cls;
      prev_ok_q  <= cls_ok;
      bad_o      <= ~cls_ok;
      locked_o   <= lock_n;
      if (lock_n) ratio_o <= cls;
    end else if (lost_i) begin
      locked_o  <= 1'b0;
      prev_ok_q <= 1'b0;
    end
  end

  p_lock_on_meas_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(meas_vld_i));
  p_ratio_stable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o && $past(locked_o) |-> $stable(ratio_o));
endmodule

// File: rtl/acr_en256.sv
module acr_en256
  import acr_pkg::*;
#(
  parameter int unsigned BASE = 256,
  localparam int unsigned ACC_W = $clog2(4 * BASE) + 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       locked_i,
  input  logic [1:0] ratio_i,
  input  logic       rise_i,
  output logic       en_o
);
  logic [ACC_W-1:0] acc_q, sum, rlen;

  always_comb begin
    rlen = ACC_W'(ratio_len(BASE, ratio_i));
    sum  = (rise_i ? '0 : acc_q) + ACC_W'(BASE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      en_o  <= 1'b0;
    end else if (!locked_i) begin
      acc_q <= '0;
      en_o  <= 1'b0;
    end else if (sum >= rlen) begin
      acc_q <= sum - rlen;
      en_o  <= 1'b1;
    end else begin
      acc_q <= sum;
      en_o  <= 1'b0;
    end
  end

  p_en_needs_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> $past(locked_i));
endmodule

// File: rtl/acr_master_div.sv
module acr_master_div #(
  parameter int unsigned BASE       = 256,
  parameter int unsigned BCK_PER_FS = 64,
  localparam int unsigned DIV_W = $clog2(2 * BASE),
  localparam int unsigned LB    = $clog2(BASE),
  localparam int unsigned BB    = $clog2(BASE / BCK_PER_FS) - 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic sel_i,
  output logic lrck_o,
  output logic bclk_o
);
  logic [DIV_W-1:0] div_q, last;

  assign last   = sel_i ? DIV_W'(2 * BASE - 1) : DIV_W'(BASE - 1);
  assign lrck_o = sel_i ? div_q[LB] : div_q[LB-1];
  assign bclk_o = sel_i ? div_q[BB+1] : div_q[BB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            div_q <= '0;
    else if (!master_i)     div_q <= '0;
    else if (div_q >= last) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  p_bclk_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lrck_o) && $stable(sel_i) |-> !bclk_o);
endmodule

// File: rtl/fs_ratio_clk_ctrl.sv
module fs_ratio_clk_ctrl #(
  parameter int unsigned BASE       = 256,
  parameter int unsigned TOL        = 2,
  parameter int unsigned LOSS_CYC   = 1024,
  parameter int unsigned BCK_PER_FS = 64,
  localparam int unsigned CNT_W = $clog2(LOSS_CYC + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lrck_i,
  input  logic       master_i,
  input  logic       ratio_sel_i,
  input  logic       pwr_en_i,
  output logic       lrck_o,
  output logic       bclk_o,
  output logic       en256_o,
  output logic [1:0] ratio_o,
  output logic       ratio_ok_o,
  output logic       bad_ratio_o,
  output logic       clk_lost_o,
  output logic       pd_o
);
  logic             lrck_gen, lrck_src, rise, meas_vld;
  logic [CNT_W-1:0] meas;

  acr_master_div #(.BASE(BASE), .BCK_PER_FS(BCK_PER_FS)) u_div (
    .clk_i, .rst_ni, .master_i, .sel_i(ratio_sel_i),
    .lrck_o(lrck_gen), .bclk_o(bclk_o)
  );

  // master mode measures its own frame clock
  assign lrck_src = master_i ? lrck_gen : lrck_i;
  assign lrck_o   = lrck_gen;

  acr_lrck_meter #(.LOSS_CYC(LOSS_CYC)) u_meter (
    .clk_i, .rst_ni, .lrck_i(lrck_src), .rise_o(rise),
    .meas_vld_o(meas_vld), .meas_o(meas), .lost_o(clk_lost_o)
  );

  acr_ratio_judge #(.BASE(BASE), .TOL(TOL), .CNT_W(CNT_W)) u_judge (
    .clk_i, .rst_ni, .meas_vld_i(meas_vld), .meas_i(meas), .lost_i(clk_lost_o),
    .locked_o(ratio_ok_o), .ratio_o(ratio_o), .bad_o(bad_ratio_o)
  );

  acr_en256 #(.BASE(BASE)) u_en (
    .clk_i, .rst_ni, .locked_i(ratio_ok_o), .ratio_i(ratio_o),
    .rise_i(rise), .en_o(en256_o)
  );

  assign pd_o = ~pwr_en_i | ~ratio_ok_o;

  p_loss_unlocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_lost_o && $past(clk_lost_o) |-> !ratio_ok_o);
  p_slave_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i && $past(!master_i) |-> !lrck_o && !bclk_o);
endmodule

// File: tb/fs_ratio_clk_ctrl_tb.sv
`timescale 1ns/100ps
module fs_ratio_clk_ctrl_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, lrck_drv = 1'b0, master = 1'b0, sel = 1'b0, pwr_en = 1'b1;
  logic lrck_o, bclk_o, en_o, ok_o, bad_o, lost_o, pd_o;
  logic [1:0] ratio_o;

  fs_ratio_clk_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lrck_i(lrck_drv), .master_i(master),
    .ratio_sel_i(sel), .pwr_en_i(pwr_en), .lrck_o(lrck_o), .bclk_o(bclk_o),
    .en256_o(en_o), .ratio_o(ratio_o), .ratio_ok_o(ok_o), .bad_ratio_o(bad_o),
    .clk_lost_o(lost_o), .pd_o(pd_o)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int class_of(int m);
    int lens[4] = '{256, 384, 512, 768};
    foreach (lens[i]) if (m >= lens[i] - 2 && m <= lens[i] + 2) return i;
    return -1;
  endfunction

  // behavioural reference
  bit m_q[$];
  int m_cnt, m_pcls, m_code, m_div;
  bit m_seen, m_pok, m_lk, m_bad;
  always @(posedge clk) begin
    int p, c;
    bit gen, rise, lost, src;
    if (!rst_n) begin
      m_q = '{0, 0, 0};
      m_cnt = 0; m_pcls = 0; m_code = 0; m_div = 0;
      m_seen = 0; m_pok = 0; m_lk = 0; m_bad = 0;
    end else begin
      p    = sel ? 512 : 256;
      gen  = master && (m_div >= p / 2);
      src  = master ? gen : lrck_drv;
      rise = m_q[1] && !m_q[2];
      lost = (m_cnt == 1024);
      if (rise && m_seen) begin
        c = class_of(m_cnt);
        m_lk  = (c >= 0) && m_pok && (c == m_pcls);
        if (m_lk) m_code = c;
        m_bad = (c < 0);
        m_pok = (c >= 0);
        m_pcls = c;
      end else if (lost) begin
        m_lk = 0; m_pok = 0;
      end
      if (rise) m_seen = 1; else if (lost) m_seen = 0;
      if (rise) m_cnt = 1; else if (m_cnt != 1024) m_cnt++;
      m_div = !master ? 0 : (m_div >= p - 1) ? 0 : m_div + 1;
      void'(m_q.pop_back());
      m_q.push_front(src);
    end
  end

  bit en_chk = 0, lk_prev = 0, drv_prev = 0;
  int en_cnt = 0;
  always @(negedge clk) begin
    int p;
    if (rst_n) begin
      p = sel ? 512 : 256;
      chk(master ? "R6" : "R2", "ratio_ok", ok_o, m_lk);
      if (m_lk) chk(master ? "R6" : "R1", "ratio code", ratio_o, m_code);
      chk("R3", "bad_ratio", bad_o, m_bad);
      chk("R7", "clk_lost", lost_o, m_cnt == 1024);
      chk("R8", "pd", pd_o, !pwr_en || !m_lk);
      chk(master ? "R5" : "R9", "lrck_o", lrck_o, master && (m_div >= p / 2));
      chk(master ? "R5" : "R9", "bclk_o", bclk_o, master && ((m_div % (p / 64)) >= p / 128));
      if (!lk_prev) chk("R4", "en while unlocked", en_o, 0);
      if (lrck_drv && !drv_prev) begin
        if (en_chk) chk("R4", "enables per frame", en_cnt, 256);
        en_cnt = 0;
      end
      en_cnt += int'(en_o);
      drv_prev = lrck_drv;
      lk_prev = m_lk;
    end else begin
      lk_prev = 0;
    end
  end

  task automatic level(bit v, int cyc);
    @(posedge clk); #1 lrck_drv = v;
    repeat (cyc - 1) @(posedge clk);
  endtask

  task automatic frames(int r, int n, bit ck);
    for (int i = 0; i < n; i++) begin
      en_chk = ck && (i >= 5);
      level(1, r / 2);
      level(0, r - r / 2);
    end
    en_chk = 0;
  endtask

  task automatic do_reset(bit ms, bit s);
    @(posedge clk); #1 rst_n = 0; master = ms; sel = s; lrck_drv = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic expect_lock(string req, int code);
    @(negedge clk);
    chk(req, "locked", ok_o, 1);
    chk(req, "code", ratio_o, code);
    chk(req, "pd released", pd_o, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8", "pd in reset", pd_o, 1);
    chk("R2", "ok in reset", ok_o, 0);
    chk("R4", "en in reset", en_o, 0);
    do_reset(0, 0);
    @(negedge clk);
    chk("R8", "pd after reset", pd_o, 1);
    frames(256, 8, 1); expect_lock("R1", 0);
    frames(384, 8, 1); expect_lock("R1", 1);
    frames(512, 8, 1); expect_lock("R1", 2);
    frames(768, 8, 1); expect_lock("R1", 3);
    frames(386, 4, 0); expect_lock("R1", 1);
    frames(258, 4, 0); expect_lock("R1", 0);
    frames(259, 3, 0);
    @(negedge clk);
    chk("R3", "bad at 259", bad_o, 1);
    chk("R3", "unlocked at 259", ok_o, 0);
    chk("R8", "pd at 259", pd_o, 1);
    for (int k = 0; k < 2; k++) begin
      frames(256, 1, 0);
      frames(512, 1, 0);
    end
    @(negedge clk);
    chk("R2", "alternating never locks", ok_o, 0);
    chk("R3", "bad cleared", bad_o, 0);
    frames(512, 4, 0); expect_lock("R2", 2);
    @(posedge clk); #1 pwr_en = 0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R8", "pd forced", pd_o, 1);
    chk("R8", "lock kept", ok_o, 1);
    @(posedge clk); #1 pwr_en = 1;
    level(0, 1100);
    @(negedge clk);
    chk("R7", "loss flagged", lost_o, 1);
    chk("R7", "loss unlocks", ok_o, 0);
    chk("R8", "pd on loss", pd_o, 1);
    frames(512, 7, 1); expect_lock("R10", 2);
    chk("R10", "loss cleared", lost_o, 0);
    do_reset(1, 0);
    #1 lrck_drv = 1;
    repeat (256 * 6) @(posedge clk);
    expect_lock("R6", 0);
    do_reset(1, 1);
    repeat (512 * 6) @(posedge clk);
    expect_lock("R6", 2);
    finish_run();
  end
endmodule